// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the memory below it. The processor posts word writes into the block and moves on without waiting for memory. Each slot of the buffer holds one aligned block of four words, together with a bit per word that marks whether that word holds data. When a new write falls in a block that a waiting slot already holds, the word goes into that slot and no new slot is used. A run of writes to neighbouring words therefore leaves the block as one masked multi-word memory write.

Slots leave for memory one at a time, oldest first, over a valid/ready handshake. Reads are free to go to memory ahead of the writes that are still waiting. For that reason the block offers a combinational lookup: given a block address, it returns, word by word, any data still waiting in the buffer. The read path uses these words in place of the ones memory returns. A slot that is on offer to memory no longer takes merges. When every slot is busy and a write cannot merge, the write port stalls.

Top module: `wbuf_merge`

## Requirements
- R1: After reset `wr_ready` is 1, `mem_valid` is 0 and `rd_fwd_mask` is 0 for any `rd_blk`.
- R2: A write is accepted (`wr_ready` high) in the cycle it is presented whenever a slot is free or a slot that is not on offer holds the same block.
- R3: `wr_addr` is split into a block address (upper `BLK_W` bits) and a word index (lowest two bits). A write whose block matches a held slot that is not on offer sets that word's mask bit and overwrites that word, and uses no new slot. Four writes to the words of one block leave as one transfer with mask 4'b1111. An offered mask is never zero.
- R4: The oldest slot is offered (`mem_valid` high) when more than one slot is held, when all four of its mask bits are set, or once it has been the oldest slot for `HOLD` clock edges.
- R5: Slots are written to memory in the order they were allocated, whatever later merges they took.
- R6: Once offered, `mem_valid`, `mem_blk`, `mem_mask` and `mem_data` hold steady until a cycle with `mem_ready` high.
- R7: A write to the block of the slot on offer does not merge into it. It allocates a new slot, so the two leave as two transfers.
- R8: When all `DEPTH` slots are held and no slot that is not on offer matches the write, `wr_ready` is 0 and the write is not taken until a slot drains.
- R9: `rd_fwd_mask` bit w is 1 exactly when some held slot for `rd_blk` has word w set. Word w of `rd_fwd_data` comes from the newest such slot. The lookup reflects the state before any write accepted in the same cycle.
- R10: Word w of a block sits at bits `[w*DATA_W +: DATA_W]` of `mem_data` and `rd_fwd_data`, and at bit w of `mem_mask` and `rd_fwd_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor posts a word write |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | BLK_W+2 | Word address: block address and word index |
| wr_data | input | DATA_W | Write data |
| rd_blk | input | BLK_W | Block address looked up for a read |
| rd_fwd_mask | output | 4 | Words of `rd_blk` found in the buffer |
| rd_fwd_data | output | 4*DATA_W | Buffered words of `rd_blk` |
| mem_valid | output | 1 | A block write is on offer to memory |
| mem_ready | input | 1 | Memory takes the offered block |
| mem_blk | output | BLK_W | Block address of the offered write |
| mem_mask | output | 4 | Words present in the offered write |
| mem_data | output | 4*DATA_W | Data of the offered write |

## Verification
The bench goes after merges into a slot that is not the oldest. A design that allocated there instead would produce an extra transfer and break the expected order. It also writes to the block of the slot already on offer. A design that merged there would change the payload during the handshake or lose a word. Other cases are the lone partial slot, which must leave after exactly `HOLD` edges and would otherwise stick or leave early; a full buffer, where a non-matching write must stall while a matching one is still taken; and duplicate slots for one block, where read forwarding must prefer the newest word rather than stale data.

// File: rtl/wbuf_merge.sv
module wbuf_merge #(
  parameter int BLK_W  = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int HOLD   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [BLK_W+1:0]      wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [BLK_W-1:0]      rd_blk,
  output logic [3:0]            rd_fwd_mask,
  output logic [4*DATA_W-1:0]   rd_fwd_data,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [BLK_W-1:0]      mem_blk,
  output logic [3:0]            mem_mask,
  output logic [4*DATA_W-1:0]   mem_data
);
  localparam int WORDS = 4;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AGE_W = $clog2(HOLD + 2);

  logic [BLK_W-1:0]        e_blk [DEPTH];
  logic [WORDS-1:0]        e_msk [DEPTH];
  logic [WORDS*DATA_W-1:0] e_dat [DEPTH];

  logic [PTR_W-1:0] head, tail, hidx, wslot;
  logic [CNT_W-1:0] cnt;
  logic [AGE_W-1:0] age;
  logic             hit_any, wr_fire, alloc, pop;

  wire [BLK_W-1:0] wr_blk = wr_addr[BLK_W+1:2];
  wire [1:0]       wr_idx = wr_addr[1:0];
  wire [WORDS-1:0] wr_bit = WORDS'(1) << wr_idx;

  assign mem_valid = (cnt != '0) &&
                     (cnt > CNT_W'(1) || (&e_msk[head]) || age >= AGE_W'(HOLD));
  assign mem_blk   = e_blk[head];
  assign mem_mask  = e_msk[head];
  assign mem_data  = e_dat[head];
  assign pop       = mem_valid && mem_ready;

  always_comb begin
    logic [PTR_W-1:0] off;
    hit_any = 1'b0;
    hidx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      off = PTR_W'(i) - head;
      if (CNT_W'(off) < cnt && e_blk[i] == wr_blk &&
          !(mem_valid && PTR_W'(i) == head)) begin
        hit_any = 1'b1;
        hidx    = PTR_W'(i);
      end
    end
  end

  assign wr_ready = hit_any || cnt != CNT_W'(DEPTH);
  assign wr_fire  = wr_valid && wr_ready;
  assign alloc    = wr_fire && !hit_any;
  assign wslot    = alloc ? tail : hidx;

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      if (alloc) begin
        e_blk[wslot] <= wr_blk;
        e_msk[wslot] <= wr_bit;
      end else begin
        e_msk[wslot] <= e_msk[wslot] | wr_bit;
      end
      for (int w = 0; w < WORDS; w++)
        if (wr_idx == 2'(w)) e_dat[wslot][w*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      age  <= '0;
    end else begin
      if (alloc) tail <= tail + PTR_W'(1);
      if (pop)   head <= head + PTR_W'(1);
      cnt <= cnt + CNT_W'(alloc) - CNT_W'(pop);
      if (pop || cnt == '0)          age <= '0;
      else if (age < AGE_W'(HOLD))   age <= age + AGE_W'(1);
    end
  end

  always_comb begin
    logic [PTR_W-1:0] s;
    rd_fwd_mask = '0;
    rd_fwd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = head + PTR_W'(k);
      if (CNT_W'(k) < cnt && e_blk[s] == rd_blk)
        for (int w = 0; w < WORDS; w++)
          if (e_msk[s][w]) begin
            rd_fwd_mask[w] = 1'b1;
            rd_fwd_data[w*DATA_W +: DATA_W] = e_dat[s][w*DATA_W +: DATA_W];
          end
    end
  end
endmodule

// File: rtl/wbuf_merge_chk.sv
module wbuf_merge_chk #(
  parameter int BLK_W  = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [BLK_W+1:0]    wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [BLK_W-1:0]    rd_blk,
  input logic [3:0]          rd_fwd_mask,
  input logic [4*DATA_W-1:0] rd_fwd_data,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [BLK_W-1:0]    mem_blk,
  input logic [3:0]          mem_mask,
  input logic [4*DATA_W-1:0] mem_data,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  logic              lw_valid;
  logic [BLK_W+1:0]  lw_addr;
  logic [DATA_W-1:0] lw_data, fwd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) lw_valid <= 1'b0;
    else        lw_valid <= wr_valid && wr_ready;
    lw_addr <= wr_addr;
    lw_data <= wr_data;
  end

  always_comb begin
    fwd_word = '0;
    for (int w = 0; w < 4; w++)
      if (lw_addr[1:0] == 2'(w)) fwd_word = rd_fwd_data[w*DATA_W +: DATA_W];
  end

  AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_blk) && $stable(mem_mask) && $stable(mem_data)); // R6
  AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> mem_valid); // R8
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_mask != 4'b0000); // R3
  AST_FWD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid && rd_blk == lw_addr[BLK_W+1:2] |-> rd_fwd_mask[lw_addr[1:0]] && fwd_word == lw_data); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R2
endmodule

bind wbuf_merge wbuf_merge_chk #(.BLK_W(BLK_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_blk(rd_blk),
  .rd_fwd_mask(rd_fwd_mask), .rd_fwd_data(rd_fwd_data),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk(mem_blk),
  .mem_mask(mem_mask), .mem_data(mem_data), .cnt(cnt));

// File: tb/test_wbuf_merge.sv
module test_wbuf_merge;
  localparam int HOLD = 4;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready, mem_valid, mem_ready = 0;
  logic [9:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] rd_blk = '0, mem_blk;
  logic [3:0] rd_fwd_mask, mem_mask;
  logic [127:0] rd_fwd_data, mem_data;

  always #5 clk = ~clk;

  wbuf_merge #(.BLK_W(8), .DATA_W(32), .DEPTH(4), .HOLD(HOLD)) i_wbuf_merge (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0]   q_blk[$];
  logic [3:0]   q_msk[$];
  logic [127:0] q_dat[$];
  string        q_tag[$];

  function automatic logic [127:0] wm(input logic [3:0] m);
    for (int w = 0; w < 4; w++) wm[w*32 +: 32] = {32{m[w]}};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic [3:0] m, input logic [127:0] d, input string t);
    q_blk.push_back(b); q_msk.push_back(m); q_dat.push_back(d); q_tag.push_back(t);
  endtask

  task automatic wr(input logic [7:0] b, input logic [1:0] w, input logic [31:0] d);
    wr_valid = 1; wr_addr = {b, w}; wr_data = d;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic drain_all();
    mem_ready = 1;
    while (q_blk.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  logic waiting = 0;
  logic [7:0] w_blk; logic [3:0] w_msk; logic [127:0] w_dat;
  always @(negedge clk) if (rst_n) begin
    if (waiting)
      check(mem_valid && mem_blk == w_blk && mem_mask == w_msk && mem_data == w_dat,
            "R6 offer held", {mem_valid, mem_blk, mem_mask, mem_data}, {1'b1, w_blk, w_msk, w_dat});
    if (mem_valid && mem_ready) begin
      waiting = 0;
      if (q_blk.size() == 0) check(0, "R5 unexpected transfer", {mem_blk, mem_mask}, '0);
      else begin
        check(mem_blk == q_blk[0] && mem_mask == q_msk[0] &&
              (mem_data & wm(q_msk[0])) == (q_dat[0] & wm(q_msk[0])),
              q_tag[0], {mem_blk, mem_mask, mem_data & wm(mem_mask)}, {q_blk[0], q_msk[0], q_dat[0] & wm(q_msk[0])});
        void'(q_blk.pop_front()); void'(q_msk.pop_front());
        void'(q_dat.pop_front()); void'(q_tag.pop_front());
      end
    end else if (mem_valid) begin
      waiting = 1; w_blk = mem_blk; w_msk = mem_mask; w_dat = mem_data;
    end else waiting = 0;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(wr_ready && !mem_valid && rd_fwd_mask == 0, "R1 reset state",
          {wr_ready, mem_valid, rd_fwd_mask}, {1'b1, 1'b0, 4'b0});
    @(posedge clk); #1;

    // R3: four words merge into one transfer
    mem_ready = 1;
    push(8'h10, 4'hF, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, "R3 merged block");
    wr(8'h10, 0, 32'hA0); wr(8'h10, 1, 32'hA1);
    @(negedge clk);
    check(!mem_valid, "R4 partial lone slot not offered early", mem_valid, 0);
    @(posedge clk); #1;
    wr(8'h10, 2, 32'hA2); wr(8'h10, 3, 32'hA3);
    drain_all();

    // R4: lone partial slot leaves after HOLD edges
    push(8'h21, 4'b0100, {32'h0, 32'hB2, 64'h0}, "R10 partial word2 transfer");
    wr(8'h21, 2, 32'hB2);
    begin
      int k = 0;
      @(negedge clk);
      while (!mem_valid && k < 20) begin k++; @(negedge clk); end
      check(k == HOLD, "R4 hold edges", k, HOLD);
    end
    drain_all();

    // R5: order kept, merge into non-oldest slot
    mem_ready = 0;
    push(8'h30, 4'b0001, {96'h0, 32'hC0}, "R5 order first");
    push(8'h31, 4'b0110, {32'h0, 32'hD2, 32'hD1, 32'h0}, "R5 order second merged");
    push(8'h32, 4'b1000, {32'hE3, 96'h0}, "R5 order third");
    wr(8'h30, 0, 32'hC0); wr(8'h31, 1, 32'hD1); wr(8'h32, 3, 32'hE3);
    wr(8'h31, 2, 32'hD2);
    rd_blk = 8'h31;
    @(negedge clk);
    check(rd_fwd_mask == 4'b0110 && (rd_fwd_data & wm(4'b0110)) == {32'h0, 32'hD2, 32'hD1, 32'h0},
          "R9 forward merged slot", {rd_fwd_mask, rd_fwd_data & wm(4'b0110)}, {4'b0110, 32'h0, 32'hD2, 32'hD1, 32'h0});
    check(wr_ready, "R2 free slot accepts", wr_ready, 1);
    @(posedge clk); #1;
    drain_all();

    // R7: offered slot takes no merge; newest wins in forwarding
    mem_ready = 0;
    push(8'h40, 4'b0001, {96'h0, 32'hF0}, "R7 offered slot untouched");
    push(8'h40, 4'b0011, {64'h0, 32'hF1, 32'hF9}, "R7 second slot");
    wr(8'h40, 0, 32'hF0);
    repeat (HOLD + 1) @(negedge clk);
    check(mem_valid, "R4 offered after hold", mem_valid, 1);
    @(posedge clk); #1;
    wr(8'h40, 1, 32'hF1); wr(8'h40, 0, 32'hF9);
    rd_blk = 8'h40;
    @(negedge clk);
    check(rd_fwd_mask == 4'b0011 && rd_fwd_data[63:0] == {32'hF1, 32'hF9}, "R9 newest slot wins",
          {rd_fwd_mask, rd_fwd_data[63:0]}, {4'b0011, 32'hF1, 32'hF9});
    @(posedge clk); #1;
    drain_all();

    // R8: full buffer stalls a non-matching write
    mem_ready = 0;
    push(8'h50, 4'b0001, {96'h0, 32'h50}, "R8 full slot0");
    push(8'h51, 4'b0001, {96'h0, 32'h51}, "R8 full slot1");
    push(8'h52, 4'b1001, {32'h99, 64'h0, 32'h52}, "R2 merge while full");
    push(8'h53, 4'b0001, {96'h0, 32'h53}, "R8 full slot3");
    push(8'h54, 4'b0001, {96'h0, 32'h54}, "R8 stalled write");
    for (int i = 0; i < 4; i++) wr(8'h50 + 8'(i), 0, 32'h50 + i);
    wr_valid = 1; wr_addr = {8'h54, 2'd0}; wr_data = 32'h54;
    repeat (3) begin
      @(negedge clk);
      check(!wr_ready && mem_valid, "R8 stall while full", {wr_ready, mem_valid}, 2'b01);
    end
    @(posedge clk); #1;
    wr(8'h52, 3, 32'h99);
    wr_valid = 1; wr_addr = {8'h54, 2'd0}; wr_data = 32'h54;
    @(negedge clk);
    check(!wr_ready, "R8 stall after merge", wr_ready, 0);
    @(posedge clk); #1 mem_ready = 1;
    wr(8'h54, 0, 32'h54);
    drain_all();

    rd_blk = 8'h77;
    @(negedge clk);
    check(rd_fwd_mask == 0, "R9 miss gives empty mask", rd_fwd_mask, 0);
    check(!mem_valid && q_blk.size() == 0, "R5 all transfers seen", {mem_valid, 8'(q_blk.size())}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule